// File: doc/BRIEF.md
# Programmable Interrupt Aggregator

The block collects up to thirty-two interrupt requests and presents them to a processor as two request lines. One line is for urgent work and the other is for ordinary work. Each request input has its own configuration. An active-level bit chooses whether the source asserts high or low. A detection-mode bit chooses between following the level and latching an edge. A routing bit sends the source to the urgent line or to the ordinary line. A mask bit enables or disables the source. Every input first passes through a two-stage synchronizer. A third register holds the previous synchronized value so that edges can be detected.

Software uses a small word-addressed register bus with an address, a write strobe, write data and combinational read data. It can read the raw latched status and the status filtered by the enable mask. A vector register names the winning pending source. Latched edge events are acknowledged by writing ones to the status register. A single configuration bit reverses the priority order used by the vector.

Top module: `irq_hub`

## Requirements
- R1: After reset, every configuration register and the status register read 0. The vector reads all ones. Both request outputs are low.
- R2: The word addresses are: 0 enable, 1 routing (1 = urgent line), 2 active level (1 = active low), 3 detection mode (1 = edge), 4 status, 5 masked status, 6 vector, 7 vector configuration (bit 0 only). Writes to addresses 0 to 3 and 7 read back; the unused bits of address 7 read 0.
- R3: A source in level mode sets its status bit on the third rising clock edge after its input becomes active, and clears it on the third edge after the input goes inactive. Writing a one to that status bit does not clear it while the input stays active.
- R4: With the active-level bit set, a low input is the active state and a high input is the inactive state.
- R5: A source in edge mode latches its status bit on an inactive-to-active transition. The bit stays set after the input returns inactive. A write with a one at that bit position clears it on the next clock edge; a write of zero leaves it set. An input held active does not set the bit again.
- R6: Address 5 reads the status ANDed with the enable register.
- R7: The urgent output is the OR of the masked status bits whose routing bit is 1. The ordinary output is the OR of the masked status bits whose routing bit is 0.
- R8: When vector configuration bit 0 is 0, the vector reads the index of the lowest-numbered masked pending source, or all ones when no masked source is pending.
- R9: When vector configuration bit 0 is 1, the vector reads the index of the highest-numbered masked pending source.
- R10: Writes to addresses 5 and 6 change no register and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Asynchronous interrupt request inputs |
| bus_addr | input | 3 | Word address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| crit_irq | output | 1 | Urgent request line |
| ncrit_irq | output | 1 | Ordinary request line |

## Verification
A change on an interrupt input reaches the status register, the masked view, the vector and both request lines on the third rising edge after the change: two synchronizer stages, then the status register. A register write takes effect on the rising edge that samples the strobe, and read data follows the address with no clock. The bench therefore changes inputs on a falling edge. It waits exactly three falling edges before it samples an input-driven result, and it reads back a write on the falling edge that follows it. This also means a result that arrives one edge late is reported.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ENABLE = 3'd0,
        SEL_ROUTE  = 3'd1,
        SEL_LEVEL  = 3'd2,
        SEL_MODE   = 3'd3,
        SEL_STATUS = 3'd4,
        SEL_MASKED = 3'd5,
        SEL_VECTOR = 3'd6,
        SEL_VCFG   = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] din,
    output logic [NSRC-1:0] sync_q,
    output logic [NSRC-1:0] prev_q
);

    logic [NSRC-1:0] meta_q;

    // two synchronizer stages plus a history register for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

endmodule

// File: rtl/irq_hub_detect.sv
module irq_hub_detect #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] sync_q,
    input  logic [NSRC-1:0] prev_q,
    input  logic [NSRC-1:0] low_act,
    input  logic [NSRC-1:0] edge_mode,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] stat
);

    logic [NSRC-1:0] act_now;
    logic [NSRC-1:0] act_old;
    logic [NSRC-1:0] stat_d;

    assign act_now = sync_q ^ low_act;
    assign act_old = prev_q ^ low_act;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_comb begin
            if (edge_mode[i]) begin
                // a new event wins over a clear in the same cycle
                stat_d[i] = (stat[i] & ~clr_mask[i]) | (act_now[i] & ~act_old[i]);
            end else begin
                stat_d[i] = act_now[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= stat_d;
        end
    end

    logic [NSRC-1:0] hold_set;
    assign hold_set = stat & edge_mode & ~clr_mask;

    // R3: level-mode bits track the active level one edge later
    p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(edge_mode)) == ($past(act_now) & ~$past(edge_mode))));

    // R5: a latched edge bit not being cleared stays set
    p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & $past(hold_set)) == $past(hold_set)));

endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
    parameter int NSRC   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   masked,
    input  logic              rev,
    output logic [DATA_W-1:0] vec_word,
    output logic              any
);

    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [IW-1:0] idx;

    always_comb begin
        idx = '0;
        for (int k = 0; k < NSRC; k++) begin
            // the last match in scan order is the winner
            if (rev) begin
                if (masked[k]) idx = IW'(k);
            end else begin
                if (masked[NSRC-1-k]) idx = IW'(NSRC-1-k);
            end
        end
    end

    assign any      = |masked;
    assign vec_word = any ? DATA_W'(idx) : '1;

    // R8: nothing pending gives the all-ones vector
    p_vec_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !any |-> (vec_word == '1));

    // R8: a reported vector always names a pending source
    p_vec_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> masked[idx]);

endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   stat,
    input  logic [NSRC-1:0]   masked,
    input  logic [DATA_W-1:0] vec_word,
    output logic [NSRC-1:0]   en,
    output logic [NSRC-1:0]   route,
    output logic [NSRC-1:0]   low_act,
    output logic [NSRC-1:0]   edge_mode,
    output logic              rev,
    output logic [NSRC-1:0]   clr_mask,
    output logic [DATA_W-1:0] rdata
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en        <= '0;
            route     <= '0;
            low_act   <= '0;
            edge_mode <= '0;
            rev       <= 1'b0;
        end else if (we) begin
            unique case (sel)
                SEL_ENABLE: en        <= wdata[NSRC-1:0];
                SEL_ROUTE:  route     <= wdata[NSRC-1:0];
                SEL_LEVEL:  low_act   <= wdata[NSRC-1:0];
                SEL_MODE:   edge_mode <= wdata[NSRC-1:0];
                SEL_VCFG:   rev       <= wdata[0];
                default:    ;
            endcase
        end
    end

    assign clr_mask = (we && sel == SEL_STATUS) ? wdata[NSRC-1:0] : '0;

    always_comb begin
        unique case (sel)
            SEL_ENABLE: rdata = DATA_W'(en);
            SEL_ROUTE:  rdata = DATA_W'(route);
            SEL_LEVEL:  rdata = DATA_W'(low_act);
            SEL_MODE:   rdata = DATA_W'(edge_mode);
            SEL_STATUS: rdata = DATA_W'(stat);
            SEL_MASKED: rdata = DATA_W'(masked);
            SEL_VECTOR: rdata = vec_word;
            SEL_VCFG:   rdata = DATA_W'(rev);
            default:    rdata = '0;
        endcase
    end

    // R10: a write to a read-only view leaves the enable mask untouched
    p_ro_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (sel == SEL_MASKED || sel == SEL_VECTOR)) |=> $stable(en) && $stable(route));

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              crit_irq,
    output logic              ncrit_irq
);

    logic [NSRC-1:0]   sync_q, prev_q;
    logic [NSRC-1:0]   en, route, low_act, edge_mode, clr_mask;
    logic [NSRC-1:0]   stat, masked;
    logic              rev, any;
    logic [DATA_W-1:0] vec_word;

    irq_hub_sync #(.NSRC(NSRC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (irq_in),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    irq_hub_detect #(.NSRC(NSRC)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_q    (sync_q),
        .prev_q    (prev_q),
        .low_act   (low_act),
        .edge_mode (edge_mode),
        .clr_mask  (clr_mask),
        .stat      (stat)
    );

    assign masked = stat & en;

    irq_hub_prio #(.NSRC(NSRC), .DATA_W(DATA_W)) u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .masked   (masked),
        .rev      (rev),
        .vec_word (vec_word),
        .any      (any)
    );

    irq_hub_regs #(.NSRC(NSRC), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .stat      (stat),
        .masked    (masked),
        .vec_word  (vec_word),
        .en        (en),
        .route     (route),
        .low_act   (low_act),
        .edge_mode (edge_mode),
        .rev       (rev),
        .clr_mask  (clr_mask),
        .rdata     (bus_rdata)
    );

    assign crit_irq  = |(masked & route);
    assign ncrit_irq = |(masked & ~route);

    // R7: with nothing pending after masking, both lines are quiet
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !any |-> (!crit_irq && !ncrit_irq));

    // R7: any pending masked source raises at least one line
    p_some_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (crit_irq || ncrit_irq));

endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;

    localparam int NSRC   = 32;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   irq_in = '0;
    logic [2:0]        bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              crit_irq, ncrit_irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    irq_hub u_irq_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .crit_irq  (crit_irq),
        .ncrit_irq (ncrit_irq)
    );

    // entries: {inputs, enable, reverse, expected vector}
    localparam logic [96:0] TBL [0:6] = '{
        {32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 32'd0},
        {32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 32'd31},
        {32'h0000_0106, 32'hFFFF_FFFF, 1'b0, 32'd1},
        {32'h0000_0106, 32'hFFFF_FFFF, 1'b1, 32'd8},
        {32'hF000_0000, 32'h0FFF_FFFF, 1'b0, 32'hFFFF_FFFF},
        {32'h8000_0001, 32'hFFFF_FFFF, 1'b1, 32'd31},
        {32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic clean();
        @(negedge clk);
        irq_in = '0;
        for (int r = 0; r < 4; r++) wr(3'(r), 32'h0);
        wr(3'd7, 32'h0);
        settle();
        wr(3'd4, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int r = 0; r < 8; r++) begin
            rd(3'(r), rv);
            chk("R1", rv, (r == 6) ? 32'hFFFF_FFFF : 32'h0);
        end
        chk("R1", {30'b0, crit_irq, ncrit_irq}, 32'h0);

        // R2: readback of configuration registers
        wr(3'd0, 32'hA5A5_0F0F); rd(3'd0, rv); chk("R2", rv, 32'hA5A5_0F0F);
        wr(3'd1, 32'h1234_5678); rd(3'd1, rv); chk("R2", rv, 32'h1234_5678);
        wr(3'd2, 32'h00FF_0000); rd(3'd2, rv); chk("R2", rv, 32'h00FF_0000);
        wr(3'd3, 32'hC000_0003); rd(3'd3, rv); chk("R2", rv, 32'hC000_0003);
        wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, rv); chk("R2", rv, 32'h1);
        clean();

        // R8 R9: table walk in level mode, all routed to the ordinary line
        for (int i = 0; i < 7; i++) begin
            wr(3'd0, TBL[i][64:33]);
            wr(3'd7, {31'b0, TBL[i][32]});
            @(negedge clk);
            irq_in = TBL[i][96:65];
            settle();
            rd(3'd6, rv);
            chk(TBL[i][32] ? "R9" : "R8", rv, TBL[i][31:0]);
            chk("R7", {31'b0, ncrit_irq}, {31'b0, |(TBL[i][96:65] & TBL[i][64:33])});
            chk("R7", {31'b0, crit_irq}, 32'h0);
        end
        clean();

        // R3: level follows input, cannot be cleared while active
        @(negedge clk);
        irq_in = 32'h4;
        repeat (2) @(negedge clk);
        rd(3'd4, rv); chk("R3", rv, 32'h0);
        @(negedge clk);
        rd(3'd4, rv); chk("R3", rv, 32'h4);
        wr(3'd4, 32'h4);
        rd(3'd4, rv); chk("R3", rv, 32'h4);
        irq_in = 32'h0;
        settle();
        rd(3'd4, rv); chk("R3", rv, 32'h0);

        // R4: active-low source
        wr(3'd2, 32'h80);
        @(negedge clk);
        rd(3'd4, rv); chk("R4", rv, 32'h80);
        @(negedge clk);
        irq_in = 32'h80;
        settle();
        rd(3'd4, rv); chk("R4", rv, 32'h0);
        clean();

        // R5: edge latch, hold, clear
        wr(3'd3, 32'h10);
        @(negedge clk);
        irq_in = 32'h10;
        settle();
        rd(3'd4, rv); chk("R5", rv, 32'h10);
        @(negedge clk);
        irq_in = 32'h0;
        settle();
        rd(3'd4, rv); chk("R5", rv, 32'h10);
        wr(3'd4, 32'h0);
        rd(3'd4, rv); chk("R5", rv, 32'h10);
        wr(3'd4, 32'h10);
        rd(3'd4, rv); chk("R5", rv, 32'h0);
        irq_in = 32'h10;
        settle();
        wr(3'd4, 32'h10);
        repeat (2) @(negedge clk);
        rd(3'd4, rv); chk("R5", rv, 32'h0);
        clean();

        // R6 R7: masking and routing
        wr(3'd0, 32'h8);
        wr(3'd1, 32'h8);
        @(negedge clk);
        irq_in = 32'h208;
        settle();
        rd(3'd4, rv); chk("R6", rv, 32'h208);
        rd(3'd5, rv); chk("R6", rv, 32'h8);
        chk("R7", {30'b0, crit_irq, ncrit_irq}, 32'h2);
        wr(3'd0, 32'h208);
        chk("R7", {30'b0, crit_irq, ncrit_irq}, 32'h3);

        // R10: writes to read-only views
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0);
        rd(3'd4, rv); chk("R10", rv, 32'h208);
        rd(3'd0, rv); chk("R10", rv, 32'h208);
        rd(3'd6, rv); chk("R10", rv, 32'd3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule